// File: doc/BRIEF.md
# Transport stream derandomizer

This block undoes the energy-dispersal scrambling applied to a stream of 188-byte transport packets once forward error correction has finished with them. A 15-stage linear feedback shift register with feedback polynomial 1 + x^14 + x^15 produces the sequence that is XORed onto the payload. Packets come in groups of eight. The first packet of each group carries the bit-inverted sync byte 0xB8, and that byte reloads the generator with a fixed seed.

Bytes arrive with a valid strobe and a packet-start flag, which is high on the sync byte. Each descrambled byte leaves one clock later, together with its valid strobe, the packet-start flag, a group-start flag and an alignment flag. The controller has two states. ST_SEEK is the state after reset, and in it bytes pass through unchanged. Transition T_LOCK moves from ST_SEEK to ST_LOCKED when the first inverted sync byte is seen. ST_LOCKED stays in itself (T_STAY) until a synchronous reset returns the controller to ST_SEEK (T_RESET).

Top module: `ts_derandomizer`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters ST_SEEK and loads the seed. The next cycle shows `out_valid` = 0 and `out_aligned` = 0.
- R2: In ST_SEEK, every valid byte is output unchanged with `out_aligned` = 0 and `out_group` = 0, and the generator does not move.
- R3: A valid byte with `in_start` = 1 and value 0xB8 is output as 0x47 with `out_start` = 1, `out_group` = 1 and `out_aligned` = 1. It loads the generator with the seed 100101010000000 (stage 1 first, stage 15 last) and does not step it.
- R4: In ST_LOCKED, a valid byte with `in_start` = 0 is XORed with eight generator outputs, first output on bit 7. Each output is stage 14 XOR stage 15, and it is also shifted into stage 1. The first payload byte after a reload is therefore XORed with 0x03.
- R5: In ST_LOCKED, a valid byte with `in_start` = 1 and a value other than 0xB8 is output unchanged with `out_start` = 1 and `out_group` = 0. The generator still takes eight steps.
- R6: A cycle with `in_valid` = 0 leaves the generator unchanged. The next cycle shows `out_valid` = 0 with `out_start` = 0 and `out_group` = 0.
- R7: Outputs are registered, with a latency of exactly one clock: `out_valid` follows `in_valid` from the previous cycle.
- R8: A value of 0xB8 with `in_start` = 0 is treated as ordinary payload and does not reload the generator.
- R9: An inverted sync byte reloads the generator whenever it arrives in ST_LOCKED, even part-way through a packet. The next payload byte is again XORed with 0x03.
- R10: A reset in the middle of the stream clears alignment. Following bytes pass through unchanged until the next inverted sync byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Incoming byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_start | input | 1 | Incoming byte is a packet sync byte |
| out_data | output | 8 | Descrambled byte |
| out_valid | output | 1 | Output byte is valid |
| out_start | output | 1 | Output byte is a packet sync byte |
| out_group | output | 1 | Output byte starts a group of eight packets |
| out_aligned | output | 1 | Block has locked to an inverted sync byte |

## Verification
The hardest condition to reach is a generator that has run deep into its sequence. Getting there requires a full group of eight packets with no reload, with non-inverted sync bytes and idle gaps mixed into the stream, so that any slip in stepping shows up in later payload bytes. The stimulus does exactly this, then places a 0xB8 payload byte and a mid-packet inverted sync byte to exercise reload. A reference generator, written in stage-numbered form in the bench, predicts every output byte.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    typedef enum logic {
        ST_SEEK   = 1'b0,
        ST_LOCKED = 1'b1
    } tsd_state_e;

    localparam int              LFSR_LEN_DEF = 15;
    // stage 1 is bit 0; stages 1, 4, 6 and 8 hold a one
    localparam logic [14:0]     SEED_DEF     = 15'h00A9;
    localparam logic [7:0]      SYNC_INV_DEF = 8'hB8;

endpackage

// File: rtl/tsd_prbs.sv
module tsd_prbs #(
    parameter int                  LEN   = 15,
    parameter int                  TAP_A = 14,
    parameter int                  TAP_B = 15,
    parameter int                  STEPS = 8,
    parameter logic [LEN-1:0]      SEED  = 15'h00A9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             advance,
    output logic [STEPS-1:0] mask
);

    logic [LEN-1:0] state_q;
    logic [LEN-1:0] chain [0:STEPS];

    assign chain[0] = state_q;

    // one unrolled generator step per bit, first step lands on the top mask bit
    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic fb;
        assign fb               = chain[i][TAP_A-1] ^ chain[i][TAP_B-1];
        assign mask[STEPS-1-i]  = fb;
        assign chain[i+1]       = {chain[i][LEN-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state_q <= SEED;
        end else if (advance) begin
            state_q <= chain[STEPS];
        end
    end

endmodule

// File: rtl/tsd_ctrl.sv
module tsd_ctrl
    import tsd_pkg::*;
#(
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] SYNC_INV = 8'hB8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_start,
    output logic              head,
    output logic              load,
    output logic              advance,
    output logic              apply,
    output logic              aligned_now
);

    tsd_state_e state_q;
    tsd_state_e state_d;

    always_comb begin
        head    = in_valid && in_start && (in_data == SYNC_INV);
        state_d = state_q;
        unique case (state_q)
            ST_SEEK:   if (head) state_d = ST_LOCKED;   // T_LOCK
            ST_LOCKED: state_d = ST_LOCKED;             // T_STAY
            default:   state_d = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEEK;                          // T_RESET
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load        = head;
        advance     = 1'b0;
        apply       = 1'b0;
        aligned_now = head;
        unique case (state_q)
            ST_SEEK: begin
                advance = 1'b0;
                apply   = 1'b0;
            end
            ST_LOCKED: begin
                advance     = in_valid && !head;
                apply       = in_valid && !in_start;
                aligned_now = 1'b1;
            end
            default: begin
                advance = 1'b0;
                apply   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ts_derandomizer.sv
module ts_derandomizer
    import tsd_pkg::*;
#(
    parameter int                  BYTE_W   = 8,
    parameter int                  LFSR_LEN = LFSR_LEN_DEF,
    parameter int                  TAP_A    = 14,
    parameter int                  TAP_B    = 15,
    parameter logic [LFSR_LEN-1:0] SEED     = SEED_DEF,
    parameter logic [BYTE_W-1:0]   SYNC_INV = SYNC_INV_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_start,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_start,
    output logic              out_group,
    output logic              out_aligned
);

    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] data_d;
    logic              head;
    logic              load;
    logic              advance;
    logic              apply;
    logic              aligned_now;

    tsd_ctrl #(
        .BYTE_W   (BYTE_W),
        .SYNC_INV (SYNC_INV)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_start    (in_start),
        .head        (head),
        .load        (load),
        .advance     (advance),
        .apply       (apply),
        .aligned_now (aligned_now)
    );

    tsd_prbs #(
        .LEN   (LFSR_LEN),
        .TAP_A (TAP_A),
        .TAP_B (TAP_B),
        .STEPS (BYTE_W),
        .SEED  (SEED)
    ) prbs_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .mask    (mask)
    );

    always_comb begin
        if (head) begin
            data_d = ~in_data;
        end else if (apply) begin
            data_d = in_data ^ mask;
        end else begin
            data_d = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data    <= '0;
            out_valid   <= 1'b0;
            out_start   <= 1'b0;
            out_group   <= 1'b0;
            out_aligned <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_start <= in_valid && in_start;
            out_group <= head;
            if (in_valid) begin
                out_data    <= data_d;
                out_aligned <= aligned_now;
            end
        end
    end

endmodule

// File: rtl/tsd_checker.sv
module tsd_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] in_data,
    input logic       in_valid,
    input logic       in_start,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_start,
    input logic       out_group,
    input logic       out_aligned
);

    logic       prev_rst     = 1'b1;
    logic       prev_valid   = 1'b0;
    logic       prev_head    = 1'b0;
    logic       prev_aligned = 1'b0;
    logic [7:0] prev_data    = 8'h00;

    always_ff @(posedge clk) begin
        prev_rst     <= rst;
        prev_valid   <= in_valid;
        prev_head    <= in_valid && in_start && (in_data == 8'hB8);
        prev_aligned <= out_aligned;
        prev_data    <= in_data;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) prev_rst |-> !out_valid && !out_aligned); // R1
    AST_SEEK_PASSES: assert property (@(posedge clk) disable iff (rst)
        (!prev_rst && out_valid && !out_aligned) |-> (out_data == prev_data) && !out_group); // R2
    AST_HEAD_MARKS: assert property (@(posedge clk) disable iff (rst)
        (!prev_rst && prev_head) |-> out_group && out_start && out_aligned); // R3
    AST_GROUP_BYTE: assert property (@(posedge clk) disable iff (rst)
        out_group |-> (out_data == 8'h47) && out_valid); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_start && !out_group); // R6
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !prev_rst |-> (out_valid == prev_valid)); // R7
    AST_ALIGN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!prev_rst && prev_aligned) |-> out_aligned); // R10

endmodule

bind ts_derandomizer tsd_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_start    (in_start),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_start   (out_start),
    .out_group   (out_group),
    .out_aligned (out_aligned)
);

// File: tb/ts_derandomizer_tb_top.sv
module ts_derandomizer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_start;
    logic       out_group;
    logic       out_aligned;

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_derandomizer dut_i (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_start    (in_start),
        .out_data    (out_data),
        .out_valid   (out_valid),
        .out_start   (out_start),
        .out_group   (out_group),
        .out_aligned (out_aligned)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       s;
        logic       g;
        logic       a;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // reference generator, indexed by stage number
    bit [15:1] mreg;
    bit        m_locked;

    task automatic model_seed();
        mreg    = '0;
        mreg[1] = 1'b1;
        mreg[4] = 1'b1;
        mreg[6] = 1'b1;
        mreg[8] = 1'b1;
    endtask

    task automatic model_steps(output logic [7:0] m);
        bit nb;
        for (int k = 0; k < 8; k++) begin
            nb       = mreg[14] ^ mreg[15];
            mreg     = {mreg[14:1], nb};
            m[7-k]   = nb;
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic s, input string req);
        exp_t       e;
        logic [7:0] m;
        if (s && d == 8'hB8) begin
            model_seed();
            m_locked = 1'b1;
            e = '{d: 8'h47, s: 1'b1, g: 1'b1, a: 1'b1};
        end else if (m_locked) begin
            model_steps(m);
            if (s) e = '{d: d, s: 1'b1, g: 1'b0, a: 1'b1};
            else   e = '{d: d ^ m, s: 1'b0, g: 1'b0, a: 1'b1};
        end else begin
            e = '{d: d, s: s, g: 1'b0, a: 1'b0};
        end
        exp_q.push_back(e);
        tag_q.push_back(req);
        in_data  = d;
        in_start = s;
        in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        in_start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input string req);
        in_valid = 1'b0;
        in_start = 1'b0;
        rst      = 1'b1;
        m_locked = 1'b0;
        model_seed();
        repeat (2) @(negedge clk);
        check(!out_valid && !out_aligned, req, {9'b0, out_valid, out_aligned}, 11'h0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic payload(input int n, input int salt, input string req);
        for (int i = 0; i < n; i++) begin
            send(8'((i * 37 + salt) & 8'hFF), 1'b0, req);
            if (i % 61 == 60) idle(2);                 // R6 gaps inside a packet
        end
    endtask

    // monitor: compares against the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", {out_data, out_start, out_group, out_aligned}, 11'h0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_data, out_start, out_group, out_aligned} == e, t,
                          {out_data, out_start, out_group, out_aligned}, e);
                end
            end else begin
                check(!out_start && !out_group, "R6", {9'b0, out_start, out_group}, 11'h0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_seed();
        m_locked = 1'b0;
        do_reset("R1");

        // R2: unlocked bytes pass unchanged, R8: 0xB8 without start flag
        send(8'h47, 1'b1, "R2");
        send(8'h12, 1'b0, "R2");
        send(8'hB8, 1'b0, "R8");
        send(8'hFF, 1'b0, "R2");
        idle(1);

        // R3 head, R4 first payload byte carries mask 0x03
        send(8'hB8, 1'b1, "R3");
        send(8'h00, 1'b0, "R4");
        check(out_data == 8'h03, "R4", {3'b0, out_data}, 11'h003);
        payload(93, 5, "R4");
        send(8'hB8, 1'b0, "R8");
        payload(93, 11, "R4");

        // R5: seven non-inverted sync bytes, generator keeps running
        for (int p = 0; p < 7; p++) begin
            send(8'h47, 1'b1, "R5");
            payload(187, p * 3 + 1, "R5");
        end

        // R9: next group, then a reload in the middle of a packet
        send(8'hB8, 1'b1, "R9");
        payload(20, 9, "R9");
        send(8'hB8, 1'b1, "R9");
        send(8'h00, 1'b0, "R9");
        check(out_data == 8'h03, "R9", {3'b0, out_data}, 11'h003);
        payload(40, 2, "R9");
        idle(3);

        // R10: reset mid-stream drops alignment
        do_reset("R10");
        send(8'h55, 1'b0, "R10");
        send(8'h47, 1'b1, "R10");
        send(8'hA5, 1'b0, "R10");
        send(8'hB8, 1'b1, "R3");
        send(8'h00, 1'b0, "R4");
        idle(2);

        check(exp_q.size() == 0, "R7", 11'(exp_q.size()), 11'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule